// File: doc/BRIEF.md
# Processor Bus Cycle Sequencer

This block turns a one-tick request into the clock-state sequence and active-low strobes of one bus machine cycle of an 8-bit processor with a 16-bit address bus. It handles six cycle kinds: opcode fetch, memory read, memory write, port read, port write and interrupt acknowledge. Each clock state (T1, T2, wait states, T3, T4) lasts two ticks of `clk`. The first tick is the high half of the state and the second tick is the low half. This gives the strobes half-state resolution while every output still comes from a register.

The requester presents a cycle kind, an address and a write byte together with `start_i`. A read byte is captured from the data bus input at the proper point. The block pulses `done_o` in the last tick of the cycle. Opcode fetches and interrupt acknowledges end with two refresh states. During these states a 7-bit refresh counter is placed on the low address bits. Port cycles get one automatic wait state and acknowledge cycles get two. Any further wait states come from the WAIT input. The address and data buses are separate in and out ports, each with an enable.

Top module: `bus_seq_top`

## Requirements
- R1: While `rst` is high and on the tick after it, every strobe output is high, `abus_oe_o`, `dbus_oe_o` and `done_o` are low, and the refresh counter is cleared to zero.
- R2: Kind code 0 (opcode fetch) lasts states T1, T2, T3 and T4. M1 is low throughout T1, T2 and any wait states. MREQ and RD are low from the second half of T1 to the end of T2 and its wait states. The data bus is captured on the edge that begins T3.
- R3: During T3 and T4 of an opcode fetch or interrupt acknowledge, RFSH is low and M1 and RD are high. The address bus carries the refresh counter in its low 7 bits and zero above them. MREQ is low in the second half of T3 and the first half of T4.
- R4: The refresh counter advances by one at the end of every refresh period and wraps from 127 to 0.
- R5: Kind code 1 (memory read) lasts T1, T2 and T3. MREQ and RD are low from the second half of T1 through the first half of T3. The byte is captured at the middle of T3.
- R6: Kind code 2 (memory write) lasts T1, T2 and T3. MREQ is low from the second half of T1 through the first half of T3. WR is low from the second half of T2 through the first half of T3. The write byte is driven from the second half of T1 to the end of T3.
- R7: Kind codes 3 (port read) and 4 (port write) add one automatic wait state after T2. IORQ and RD, or IORQ and WR, are low from the start of T2 through the first half of T3. The address bus carries the low byte of the address with the upper byte zero. A port write drives data from the second half of T1 to the end of T3.
- R8: Kind code 5 (interrupt acknowledge) is an M1 cycle with two automatic wait states. MREQ and RD stay high before T3. IORQ is low from the second wait state onward until T3. The vector is captured on the edge that begins T3, and the refresh states follow.
- R9: WAIT is sampled in the second half of T2 and of each wait state, once the automatic wait states are used up. Each low sample adds one wait state of two ticks.
- R10: A start request is taken only while the block is idle and only with a kind code from 0 to 5. A request during a cycle, or with code 6 or 7, is ignored.
- R11: `done_o` is high for exactly the last tick of a cycle. On the next tick every strobe is high again.
- R12: Write cycles leave the captured read byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, two ticks per clock state |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to begin a cycle |
| cyc_type_i | input | 3 | Cycle kind code (0 to 5) |
| addr_i | input | AW | Cycle address |
| wdata_i | input | DW | Byte to write |
| wait_n_i | input | 1 | Wait request, active low |
| dbus_i | input | DW | Data bus input |
| abus_o | output | AW | Address bus |
| abus_oe_o | output | 1 | Address bus enable |
| dbus_o | output | DW | Data bus output |
| dbus_oe_o | output | 1 | Data bus output enable |
| m1_n_o | output | 1 | First machine cycle strobe, active low |
| mreq_n_o | output | 1 | Memory request, active low |
| iorq_n_o | output | 1 | Port request, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| rfsh_n_o | output | 1 | Refresh strobe, active low |
| rdata_o | output | DW | Last captured read byte |
| done_o | output | 1 | Last tick of the cycle |

## Verification
The bench builds the block with its defaults: a 16-bit address, an 8-bit data bus and a 7-bit refresh counter. With a 7-bit counter, the wrap from 127 to 0 is reached after 128 fetches, so R4 is checked at its boundary within a short run. The 16-bit address makes the zeroed upper port byte visible on every port cycle. Each vector measures, at the ports, how many ticks each strobe is low over a cycle with zero to three external wait states. These counts separate the half-state edges of each cycle kind.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

  typedef enum logic [2:0] {
    CYC_FETCH = 3'd0,
    CYC_MRD   = 3'd1,
    CYC_MWR   = 3'd2,
    CYC_IORD  = 3'd3,
    CYC_IOWR  = 3'd4,
    CYC_INTA  = 3'd5
  } cyc_e;

  localparam logic [2:0] CYC_LAST = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_T1, ST_T2, ST_TW, ST_T3, ST_T4
  } tst_e;

  typedef logic [1:0] twc_t;
  localparam twc_t TWC_MAX = 2'd3;

  typedef struct packed {
    logic m1_n;
    logic mreq_n;
    logic iorq_n;
    logic rd_n;
    logic wr_n;
    logic rfsh_n;
    logic dout_oe;
    logic done;
  } strb_t;

  localparam strb_t STRB_IDLE = '{m1_n: 1'b1, mreq_n: 1'b1, iorq_n: 1'b1,
                                  rd_n: 1'b1, wr_n: 1'b1, rfsh_n: 1'b1,
                                  dout_oe: 1'b0, done: 1'b0};

  function automatic logic is_m1(cyc_e c);
    return (c == CYC_FETCH) || (c == CYC_INTA);
  endfunction

  function automatic twc_t auto_waits(cyc_e c);
    case (c)
      CYC_IORD, CYC_IOWR: return 2'd1;
      CYC_INTA:           return 2'd2;
      default:            return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
  import bus_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic [2:0] type_i,
  input  logic       wait_n_i,
  output tst_e       st_q,
  output tst_e       st_d,
  output logic       ph_q,
  output logic       ph_d,
  output cyc_e       typ_q,
  output cyc_e       typ_d,
  output twc_t       twc_d,
  output logic       accept_o
);

  twc_t twc_q;
  twc_t twc_inc;
  logic more_wait;

  assign accept_o = (st_q == ST_IDLE) && start_i && (type_i <= CYC_LAST);
  assign twc_inc  = (twc_q == TWC_MAX) ? twc_q : twc_q + 2'd1;

  always_comb begin
    st_d      = st_q;
    ph_d      = ph_q;
    typ_d     = typ_q;
    twc_d     = twc_q;
    more_wait = 1'b0;
    if (st_q == ST_IDLE) begin
      if (accept_o) begin
        st_d  = ST_T1;
        ph_d  = 1'b0;
        typ_d = cyc_e'(type_i);
        twc_d = '0;
      end
    end else if (!ph_q) begin
      ph_d = 1'b1;
    end else begin
      ph_d = 1'b0;
      case (st_q)
        ST_T1: st_d = ST_T2;
        ST_T2, ST_TW: begin
          // waits completed once this state ends
          twc_d     = (st_q == ST_TW) ? twc_inc : '0;
          more_wait = (twc_d < auto_waits(typ_q)) || !wait_n_i;
          st_d      = more_wait ? ST_TW : ST_T3;
        end
        ST_T3:   st_d = is_m1(typ_q) ? ST_T4 : ST_IDLE;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      ph_q  <= 1'b0;
      typ_q <= CYC_FETCH;
      twc_q <= '0;
    end else begin
      st_q  <= st_d;
      ph_q  <= ph_d;
      typ_q <= typ_d;
      twc_q <= twc_d;
    end
  end

endmodule

// File: rtl/bus_seq_strobe.sv
module bus_seq_strobe
  import bus_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  tst_e  st_i,
  input  logic  ph_i,
  input  cyc_e  typ_i,
  input  twc_t  twc_i,
  output strb_t strb_q
);

  strb_t s;
  logic  a, b, t1, t2, tw, t3, t4;

  assign a  = !ph_i;
  assign b  = ph_i;
  assign t1 = (st_i == ST_T1);
  assign t2 = (st_i == ST_T2);
  assign tw = (st_i == ST_TW);
  assign t3 = (st_i == ST_T3);
  assign t4 = (st_i == ST_T4);

  always_comb begin
    s = STRB_IDLE;
    case (typ_i)
      CYC_FETCH, CYC_INTA: begin
        s.m1_n   = !(t1 | t2 | tw);
        s.rfsh_n = !(t3 | t4);
        s.mreq_n = !((t3 & b) | (t4 & a) |
                     ((typ_i == CYC_FETCH) & ((t1 & b) | t2 | tw)));
        s.rd_n   = !((typ_i == CYC_FETCH) & ((t1 & b) | t2 | tw));
        s.iorq_n = !((typ_i == CYC_INTA) & tw & (twc_i != '0));
        s.done   = t4 & b;
      end
      CYC_MRD, CYC_MWR: begin
        s.mreq_n  = !((t1 & b) | t2 | tw | (t3 & a));
        s.rd_n    = !((typ_i == CYC_MRD) & ((t1 & b) | t2 | tw | (t3 & a)));
        s.wr_n    = !((typ_i == CYC_MWR) & ((t2 & b) | tw | (t3 & a)));
        s.dout_oe = (typ_i == CYC_MWR) & ((t1 & b) | t2 | tw | t3);
        s.done    = t3 & b;
      end
      default: begin
        s.iorq_n  = !(t2 | tw | (t3 & a));
        s.rd_n    = !((typ_i == CYC_IORD) & (t2 | tw | (t3 & a)));
        s.wr_n    = !((typ_i == CYC_IOWR) & (t2 | tw | (t3 & a)));
        s.dout_oe = (typ_i == CYC_IOWR) & ((t1 & b) | t2 | tw | t3);
        s.done    = t3 & b;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) strb_q <= STRB_IDLE;
    else     strb_q <= s;
  end

endmodule

// File: rtl/bus_seq_refresh.sv
module bus_seq_refresh #(
  parameter int RFW = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           adv_i,
  output logic [RFW-1:0] cnt_o
);

  always_ff @(posedge clk) begin
    if (rst)        cnt_o <= '0;
    else if (adv_i) cnt_o <= cnt_o + 1'b1;
  end

endmodule

// File: rtl/bus_seq_top.sv
module bus_seq_top
  import bus_seq_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int RFW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [2:0]    cyc_type_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wait_n_i,
  input  logic [DW-1:0] dbus_i,
  output logic [AW-1:0] abus_o,
  output logic          abus_oe_o,
  output logic [DW-1:0] dbus_o,
  output logic          dbus_oe_o,
  output logic          m1_n_o,
  output logic          mreq_n_o,
  output logic          iorq_n_o,
  output logic          rd_n_o,
  output logic          wr_n_o,
  output logic          rfsh_n_o,
  output logic [DW-1:0] rdata_o,
  output logic          done_o
);

  localparam int IOAW = AW / 2;

  tst_e           st_q, st_d;
  logic           ph_q, ph_d;
  cyc_e           typ_q, typ_d;
  twc_t           twc_d;
  logic           accept;
  strb_t          strb;
  logic [RFW-1:0] rfc;
  logic [AW-1:0]  addr_h, addr_src;
  logic [DW-1:0]  wdata_h;
  logic           cap_m1, cap_rd, rf_adv, is_io_d;

  bus_seq_fsm fsm_i (
    .clk(clk), .rst(rst), .start_i(start_i), .type_i(cyc_type_i),
    .wait_n_i(wait_n_i), .st_q(st_q), .st_d(st_d), .ph_q(ph_q), .ph_d(ph_d),
    .typ_q(typ_q), .typ_d(typ_d), .twc_d(twc_d), .accept_o(accept)
  );

  bus_seq_strobe strobe_i (
    .clk(clk), .rst(rst), .st_i(st_d), .ph_i(ph_d), .typ_i(typ_d),
    .twc_i(twc_d), .strb_q(strb)
  );

  assign rf_adv = (st_q == ST_T4) && ph_q;

  bus_seq_refresh #(.RFW(RFW)) refresh_i (
    .clk(clk), .rst(rst), .adv_i(rf_adv), .cnt_o(rfc)
  );

  assign addr_src = accept ? addr_i : addr_h;
  assign is_io_d  = (typ_d == CYC_IORD) || (typ_d == CYC_IOWR);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_h    <= '0;
      wdata_h   <= '0;
      abus_o    <= '0;
      abus_oe_o <= 1'b0;
    end else begin
      if (accept) begin
        addr_h  <= addr_i;
        wdata_h <= wdata_i;
      end
      abus_oe_o <= (st_d != ST_IDLE);
      if (((st_d == ST_T3) || (st_d == ST_T4)) && is_m1(typ_d))
        abus_o <= {{(AW-RFW){1'b0}}, rfc};
      else if (st_d != ST_IDLE)
        abus_o <= is_io_d ? {{(AW-IOAW){1'b0}}, addr_src[IOAW-1:0]} : addr_src;
    end
  end

  // capture points: edge entering T3 for M1 cycles, mid T3 otherwise
  assign cap_m1 = ((st_q == ST_T2) || (st_q == ST_TW)) && ph_q &&
                  (st_d == ST_T3) && is_m1(typ_q);
  assign cap_rd = (st_q == ST_T3) && !ph_q &&
                  ((typ_q == CYC_MRD) || (typ_q == CYC_IORD));

  always_ff @(posedge clk) begin
    if (rst)                  rdata_o <= '0;
    else if (cap_m1 | cap_rd) rdata_o <= dbus_i;
  end

  assign dbus_o    = wdata_h;
  assign dbus_oe_o = strb.dout_oe;
  assign m1_n_o    = strb.m1_n;
  assign mreq_n_o  = strb.mreq_n;
  assign iorq_n_o  = strb.iorq_n;
  assign rd_n_o    = strb.rd_n;
  assign wr_n_o    = strb.wr_n;
  assign rfsh_n_o  = strb.rfsh_n;
  assign done_o    = strb.done;

endmodule

// File: rtl/bus_seq_chk.sv
module bus_seq_chk #(
  parameter int AW  = 16,
  parameter int RFW = 7
) (
  input logic            clk,
  input logic            rst,
  input logic [AW-RFW-1:0] abus_hi,
  input logic            abus_oe_o,
  input logic            dbus_oe_o,
  input logic            m1_n_o,
  input logic            mreq_n_o,
  input logic            iorq_n_o,
  input logic            rd_n_o,
  input logic            wr_n_o,
  input logic            rfsh_n_o,
  input logic            done_o
);

  // R1
  rst_idle_chk: assert property (@(posedge clk)
    rst |=> (m1_n_o && mreq_n_o && iorq_n_o && rd_n_o && wr_n_o && rfsh_n_o &&
             !dbus_oe_o && !abus_oe_o && !done_o));

  // R6
  wr_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_n_o |-> dbus_oe_o);

  // R7
  io_mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !iorq_n_o |-> mreq_n_o);

  // R3
  rfsh_addr_chk: assert property (@(posedge clk) disable iff (rst)
    !rfsh_n_o |-> (m1_n_o && rd_n_o && abus_hi == '0));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> (!done_o && m1_n_o && mreq_n_o && iorq_n_o && rd_n_o &&
                wr_n_o && rfsh_n_o));

  // R2
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_n_o |-> wr_n_o);

endmodule

bind bus_seq_top bus_seq_chk #(.AW(AW), .RFW(RFW)) chk_i (
  .clk(clk), .rst(rst), .abus_hi(abus_o[AW-1:RFW]), .abus_oe_o(abus_oe_o),
  .dbus_oe_o(dbus_oe_o), .m1_n_o(m1_n_o), .mreq_n_o(mreq_n_o),
  .iorq_n_o(iorq_n_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o),
  .rfsh_n_o(rfsh_n_o), .done_o(done_o)
);

// File: tb/bus_seq_top_tb_top.sv
module bus_seq_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  typ = 3'd0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        wait_n = 1'b1;
  logic [7:0]  dbus_in = '0;
  logic [15:0] abus;
  logic        abus_oe, dbus_oe, m1_n, mreq_n, iorq_n, rd_n, wr_n, rfsh_n, done;
  logic [7:0]  dbus_out, rdata;

  int nchk = 0;
  int nfail = 0;
  int rcnt = 0;
  logic [7:0] last_rd = 8'h00;

  always #4 clk = ~clk;

  bus_seq_top dut_i (
    .clk(clk), .rst(rst), .start_i(start), .cyc_type_i(typ), .addr_i(addr),
    .wdata_i(wdata), .wait_n_i(wait_n), .dbus_i(dbus_in), .abus_o(abus),
    .abus_oe_o(abus_oe), .dbus_o(dbus_out), .dbus_oe_o(dbus_oe),
    .m1_n_o(m1_n), .mreq_n_o(mreq_n), .iorq_n_o(iorq_n), .rd_n_o(rd_n),
    .wr_n_o(wr_n), .rfsh_n_o(rfsh_n), .rdata_o(rdata), .done_o(done)
  );

  // {poke, kind[2:0], ext waits[3:0], addr[15:0], data[7:0]}
  localparam int NV = 13;
  localparam logic [31:0] VEC [NV] = '{
    {1'b0, 3'd0, 4'd0, 16'h1234, 8'h3E},
    {1'b0, 3'd0, 4'd2, 16'h0100, 8'hC9},
    {1'b0, 3'd1, 4'd0, 16'h8000, 8'h5A},
    {1'b0, 3'd1, 4'd1, 16'h8001, 8'hA5},
    {1'b0, 3'd2, 4'd0, 16'h9000, 8'h77},
    {1'b0, 3'd2, 4'd3, 16'h9001, 8'h12},
    {1'b0, 3'd3, 4'd0, 16'hABCD, 8'h99},
    {1'b0, 3'd4, 4'd1, 16'h1234, 8'h44},
    {1'b0, 3'd5, 4'd0, 16'h2000, 8'hFF},
    {1'b0, 3'd5, 4'd2, 16'h2001, 8'h38},
    {1'b0, 3'd3, 4'd2, 16'h00FE, 8'h01},
    {1'b1, 3'd1, 4'd0, 16'h4444, 8'h6B},
    {1'b1, 3'd0, 4'd1, 16'hFFFF, 8'h00}
  };

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic int autow(input int t);
    if (t == 3 || t == 4) return 1;
    if (t == 5) return 2;
    return 0;
  endfunction

  task automatic run_cycle(input int t, input int nw, input logic [15:0] a,
                           input logic [7:0] d, input bit poke);
    int len = 0, cm1 = 0, cmreq = 0, ciorq = 0, crd = 0, cwr = 0, crf = 0, coe = 0;
    int w2 = 2 * nw;
    int lastlow = (nw == 0) ? 0 : 4 + 2 * autow(t) + 2 * (nw - 1);
    logic [15:0] a1 = '0, rfa = '0;
    logic [7:0] wb = '0;
    bit rfs = 0;
    bit wr_cyc = (t == 2 || t == 4);
    int e_len, e_m1, e_mreq, e_iorq, e_rd, e_wr, e_rf, e_oe;
    @(negedge clk);
    start = 1'b1; typ = 3'(t); addr = a; wdata = d;
    dbus_in = wr_cyc ? ~d : d;
    wait_n = 1'b1;
    @(posedge clk);
    for (int k = 1; k <= 60; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (!m1_n) cm1++;
      if (!mreq_n) cmreq++;
      if (!iorq_n) ciorq++;
      if (!rd_n) crd++;
      if (!wr_n) begin cwr++; wb = dbus_out; end
      if (!rfsh_n) begin crf++; if (!rfs) begin rfa = abus; rfs = 1; end end
      if (dbus_oe) coe++;
      if (k == 1) a1 = abus;
      if (poke && k == 3) begin start = 1'b1; typ = 3'd4; end
      wait_n = (k <= lastlow) ? 1'b0 : 1'b1;
      if (done) begin len = k; break; end
    end
    wait_n = 1'b1;
    case (t)
      0: begin e_len=8+w2;  e_m1=4+w2; e_mreq=5+w2; e_iorq=0;    e_rd=3+w2; e_wr=0;    e_rf=4; e_oe=0;    end
      1: begin e_len=6+w2;  e_m1=0;    e_mreq=4+w2; e_iorq=0;    e_rd=4+w2; e_wr=0;    e_rf=0; e_oe=0;    end
      2: begin e_len=6+w2;  e_m1=0;    e_mreq=4+w2; e_iorq=0;    e_rd=0;    e_wr=2+w2; e_rf=0; e_oe=5+w2; end
      3: begin e_len=8+w2;  e_m1=0;    e_mreq=0;    e_iorq=5+w2; e_rd=5+w2; e_wr=0;    e_rf=0; e_oe=0;    end
      4: begin e_len=8+w2;  e_m1=0;    e_mreq=0;    e_iorq=5+w2; e_rd=0;    e_wr=5+w2; e_rf=0; e_oe=7+w2; end
      default: begin e_len=12+w2; e_m1=8+w2; e_mreq=2; e_iorq=2+w2; e_rd=0; e_wr=0; e_rf=4; e_oe=0; end
    endcase
    // R9 wait states lengthen the cycle; R10 poke must not change it
    chk("R9/R10 cycle length", len, e_len);
    chk("R2/R8 M1 ticks", cm1, e_m1);
    chk("R2/R5/R6 MREQ ticks", cmreq, e_mreq);
    chk("R7/R8 IORQ ticks", ciorq, e_iorq);
    chk("R5/R7 RD ticks", crd, e_rd);
    chk("R6/R7 WR ticks", cwr, e_wr);
    chk("R3 RFSH ticks", crf, e_rf);
    chk("R6/R7 data enable ticks", coe, e_oe);
    chk("R7 T1 address", int'(a1), (t == 3 || t == 4) ? int'({8'h00, a[7:0]}) : int'(a));
    if (t == 0 || t == 5) begin
      chk("R3/R4 refresh address", int'(rfa), rcnt);
      rcnt = (rcnt + 1) % 128;
    end
    if (wr_cyc) chk("R6/R7 write byte on bus", int'(wb), int'(d));
    else last_rd = d;
    // R12 writes keep the previous captured byte
    chk("R2/R5/R8/R12 captured byte", int'(rdata), int'(last_rd));
    @(negedge clk);
    // R11 idle right after done
    chk("R11 idle after done", int'({done, m1_n, mreq_n, iorq_n, rd_n, wr_n, rfsh_n}), 7'b0111111);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 outputs during reset
    chk("R1 strobes in reset", int'({m1_n, mreq_n, iorq_n, rd_n, wr_n, rfsh_n}), 6'b111111);
    chk("R1 enables in reset", int'({abus_oe, dbus_oe, done}), 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++)
      run_cycle(int'(VEC[i][30:28]), int'(VEC[i][27:24]), VEC[i][23:8],
                VEC[i][7:0], VEC[i][31]);

    // R4 wrap of the refresh counter past 127
    for (int i = 0; i < 128; i++)
      run_cycle(0, 0, 16'(i * 3), 8'(i), 1'b0);

    // R10 kind code 6 is ignored
    begin
      int busy = 0;
      @(negedge clk);
      start = 1'b1; typ = 3'd6;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (k == 2) start = 1'b0;
        if (!mreq_n || !iorq_n || !m1_n || done || abus_oe) busy++;
      end
      chk("R10 invalid kind ignored", busy, 0);
    end

    // R1 reset in the middle of a stretched cycle
    @(negedge clk);
    start = 1'b1; typ = 3'd1; addr = 16'h7777; wait_n = 1'b0;
    repeat (6) @(negedge clk);
    start = 1'b0;
    chk("R1 cycle in progress", int'(mreq_n), 0);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 strobes after reset", int'({m1_n, mreq_n, iorq_n, rd_n, wr_n, rfsh_n}), 6'b111111);
    chk("R1 enables after reset", int'({abus_oe, dbus_oe, done}), 0);
    rst = 1'b0; wait_n = 1'b1;
    rcnt = 0; last_rd = 8'h00;
    run_cycle(0, 0, 16'h0042, 8'hE7, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule